// File: doc/BRIEF.md
# Dual-Loop Lock Indicator and Test Output Selector

This block drives the single status pin of a synthesizer that runs two phase-locked loops, a main loop and an auxiliary loop. It watches the one-cycle terminal-count strobes of the reference, main and auxiliary dividers. Each loop has its own detector that compares that loop's divider strobe with the reference strobe. The two loop verdicts are ANDed into one lock flag. A loop whose counter is switched off always counts as locked.

Two select bits from an already-latched control word can replace the lock flag on the pin with one of the raw divider strobes. This lets a test bench measure each divide ratio directly. The block also forms the main divider's clock from the prescaler output and a test input through an exclusive-OR. All logic runs on the reference-input clock. The enable and select bits are brought into that domain through two-flop synchronizers, and the pin is driven from a register.

Top module: `synth_status_out`

## Requirements
- R1: With select code 00 the pin shows the AND of the main-loop lock term and the auxiliary-loop lock term.
- R2: A comparison happens only on a clock cycle in which the reference strobe, the loop's divider strobe, or both are high. A loop becomes locked after 4 consecutive comparisons in which both strobes are high in the same cycle. Cycles with neither strobe do not break the run.
- R3: A comparison in which only one of the two strobes is high unlocks the loop at once and restarts its count from zero.
- R4: A loop whose enable bit is 0 has its lock term forced to 1. While disabled, its detector is held cleared, so it needs 4 fresh matches after being enabled again. Each loop has its own enable.
- R5: Select codes route the pin as follows. 00 gives the lock flag. 01 gives the reference strobe, which idles low and pulses high. 10 gives the auxiliary strobe inverted, which idles high and pulses low. 11 gives the main strobe inverted, which idles high and pulses low.
- R6: A synchronous active-high reset clears both detectors to unlocked, sets the synchronized select to 00, treats both enables as 1 until the synchronizers refill, and drives the pin low.
- R7: A routed strobe reaches the pin through one register. A lock change reaches the pin one cycle after the detector updates. A change on a select or enable input affects the pin on the third rising clock edge after it is applied.
- R8: The main divider clock equals prescaler output XOR test input. A test input of 1 passes the prescaler output inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-input clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tc | input | 1 | Reference divide chain terminal-count strobe |
| main_tc | input | 1 | Main divider terminal-count strobe |
| aux_tc | input | 1 | Auxiliary divider terminal-count strobe |
| main_en | input | 1 | Main loop counter enable (latched control bit) |
| aux_en | input | 1 | Auxiliary loop counter enable (latched control bit) |
| test_sel | input | 2 | Status pin routing select (latched control bits) |
| test_in | input | 1 | Test input XORed into the main divider clock |
| presc_out | input | 1 | Prescaler output |
| main_div_clk | output | 1 | Clock to the main divider |
| status_out | output | 1 | Registered status pin |

## Verification
A single reference strobe is at once a comparison event for both loop detectors and, under select 01, the pulse routed to the pin. The bench provokes this by sending strobes while a test route is selected. It checks that the pin shows the strobe with the right polarity for exactly one cycle. It then returns to select 00 and checks that the lock state the detectors built up during those same strobes is the one shown. A second overlap occurs when an enable change lands in the same cycles as strobes aimed at the disabled loop. The bench judges this by whether the re-enabled loop needs four fresh matches.

// File: rtl/synth_status_pkg.sv
package synth_status_pkg;
    typedef enum logic [1:0] {
        SEL_LOCK = 2'b00,
        SEL_REF  = 2'b01,
        SEL_AUX  = 2'b10,
        SEL_MAIN = 2'b11
    } outsel_e;

    localparam int NUM_LOOPS = 2;
    localparam int LOOP_MAIN = 0;
    localparam int LOOP_AUX  = 1;
endpackage

// File: rtl/synth_sync2.sv
module synth_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else     st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ref_ev,
    input  logic div_ev,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CNT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lock;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (!en) begin
            det_d = '0;
        end else if (ref_ev || div_ev) begin
            if (ref_ev && div_ev) begin
                if (det_q.cnt != CW'(LOCK_CNT))
                    det_d.cnt = det_q.cnt + 1'b1;
                if (det_q.cnt >= CW'(LOCK_CNT - 1))
                    det_d.lock = 1'b1;
            end else begin
                det_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '0;
        else     det_q <= det_d;
    end

    assign locked = det_q.lock;

    // R3: a lone strobe unlocks on the next edge
    p_miss_unlocks_r3: assert property (@(posedge clk) disable iff (rst)
        (en && (ref_ev != div_ev)) |=> !locked);

    // R2: lock can only appear right after a matched comparison
    p_lock_from_match_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(en && ref_ev && div_ev));

    // R4: a disabled detector is held cleared
    p_disabled_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> !locked);
endmodule

// File: rtl/synth_status_out.sv
module synth_status_out
    import synth_status_pkg::*;
#(
    parameter int LOCK_CNT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tc,
    input  logic       main_tc,
    input  logic       aux_tc,
    input  logic       main_en,
    input  logic       aux_en,
    input  logic [1:0] test_sel,
    input  logic       test_in,
    input  logic       presc_out,
    output logic       main_div_clk,
    output logic       status_out
);
    logic [1:0]           sel_raw;
    outsel_e              sel_s;
    logic [NUM_LOOPS-1:0] en_s;
    logic [NUM_LOOPS-1:0] div_ev;
    logic [NUM_LOOPS-1:0] loop_lock;
    logic [NUM_LOOPS-1:0] lock_term;

    synth_sync2 #(.W(2), .RST_VAL(2'b00)) u_sel_sync (
        .clk (clk),
        .rst (rst),
        .din (test_sel),
        .dout(sel_raw)
    );
    assign sel_s = outsel_e'(sel_raw);

    synth_sync2 #(.W(NUM_LOOPS), .RST_VAL({NUM_LOOPS{1'b1}})) u_en_sync (
        .clk (clk),
        .rst (rst),
        .din ({aux_en, main_en}),
        .dout(en_s)
    );

    assign div_ev[LOOP_MAIN] = main_tc;
    assign div_ev[LOOP_AUX]  = aux_tc;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        synth_lock_det #(.LOCK_CNT(LOCK_CNT)) u_det (
            .clk   (clk),
            .rst   (rst),
            .en    (en_s[g]),
            .ref_ev(ref_tc),
            .div_ev(div_ev[g]),
            .locked(loop_lock[g])
        );
        assign lock_term[g] = !en_s[g] || loop_lock[g];
    end

    typedef struct packed {
        logic pin;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        unique case (sel_s)
            SEL_LOCK: out_d.pin = &lock_term;
            SEL_REF:  out_d.pin = ref_tc;
            SEL_AUX:  out_d.pin = !aux_tc;
            SEL_MAIN: out_d.pin = !main_tc;
            default:  out_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign status_out   = out_q.pin;
    assign main_div_clk = presc_out ^ test_in;

    // R1: in lock mode the pin follows both loop terms together
    p_lock_and_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel_s) == SEL_LOCK) |->
            status_out == ($past(lock_term[LOOP_MAIN]) && $past(lock_term[LOOP_AUX])));

    // R5: reference route idles low
    p_ref_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_s == SEL_REF && !ref_tc) |=> !status_out);

    // R5: auxiliary and main routes idle high
    p_aux_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_s == SEL_AUX && !aux_tc) |=> status_out);
    p_main_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_s == SEL_MAIN && !main_tc) |=> status_out);

    // R6: reset leaves the pin low and the route at lock
    p_reset_state_r6: assert property (@(posedge clk)
        $past(rst) |-> (!status_out && sel_s == SEL_LOCK));
endmodule

// File: tb/synth_status_out_tb_top.sv
`timescale 1ns/1ps
module synth_status_out_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tc = 1'b0, main_tc = 1'b0, aux_tc = 1'b0;
    logic       main_en = 1'b1, aux_en = 1'b1;
    logic [1:0] test_sel = 2'b00;
    logic       test_in = 1'b1, presc_out = 1'b0;
    logic       main_div_clk, status_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    synth_status_out dut_i (
        .clk(clk), .rst(rst),
        .ref_tc(ref_tc), .main_tc(main_tc), .aux_tc(aux_tc),
        .main_en(main_en), .aux_en(aux_en), .test_sel(test_sel),
        .test_in(test_in), .presc_out(presc_out),
        .main_div_clk(main_div_clk), .status_out(status_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic m, input logic a);
        ref_tc = r; main_tc = m; aux_tc = a;
        @(negedge clk);
        ref_tc = 1'b0; main_tc = 1'b0; aux_tc = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk(status_out, 1'b0, "R6 pin low after reset");
    endtask

    task automatic t_lock_build();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
        idle(2);
        chk(status_out, 1'b0, "R2 not locked after 3 matches");
        step(1'b1, 1'b1, 1'b1);
        chk(status_out, 1'b0, "R7 lock one cycle behind detector");
        idle(1);
        chk(status_out, 1'b1, "R2 R1 locked after 4 matches");
    endtask

    task automatic t_drop();
        step(1'b1, 1'b1, 1'b0);
        idle(1);
        chk(status_out, 1'b0, "R3 R1 aux miss clears lock");
        aux_en = 1'b0;
        idle(3);
        chk(status_out, 1'b1, "R4 disabled aux counts locked");
        aux_en = 1'b1; main_en = 1'b0;
        idle(3);
        chk(status_out, 1'b0, "R4 re-enabled aux needs fresh lock");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
        idle(1);
        chk(status_out, 1'b1, "R4 aux relocked while main disabled");
        main_en = 1'b1;
        idle(3);
        chk(status_out, 1'b0, "R4 main cleared while disabled");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
        idle(1);
        chk(status_out, 1'b1, "R2 both loops locked again");
    endtask

    task automatic t_gap_tolerance();
        step(1'b1, 1'b1, 1'b0);
        idle(1);
        chk(status_out, 1'b0, "R3 aux miss");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, 1'b1);
            idle(2);
        end
        chk(status_out, 1'b1, "R2 idle gaps keep the run");
    endtask

    task automatic t_routes();
        test_sel = 2'b10;
        idle(2);
        chk(status_out, 1'b1, "R7 select not yet applied");
        step(1'b0, 1'b0, 1'b0);
        chk(status_out, 1'b1, "R5 aux route idles high");
        step(1'b0, 1'b0, 1'b1);
        chk(status_out, 1'b0, "R5 R7 aux pulse low one register");
        idle(1);
        chk(status_out, 1'b1, "R5 aux pulse one cycle");
        test_sel = 2'b01;
        idle(3);
        chk(status_out, 1'b0, "R5 ref route idles low");
        step(1'b1, 1'b0, 1'b0);
        chk(status_out, 1'b1, "R5 ref pulse high");
        idle(1);
        chk(status_out, 1'b0, "R5 ref pulse one cycle");
        test_sel = 2'b11;
        idle(3);
        chk(status_out, 1'b1, "R5 main route idles high");
        step(1'b0, 1'b1, 1'b0);
        chk(status_out, 1'b0, "R5 main pulse low");
        idle(1);
        chk(status_out, 1'b1, "R5 main pulse one cycle");
        test_sel = 2'b00;
        idle(3);
        chk(status_out, 1'b0, "R3 lone strobes under test routes unlocked");
    endtask

    task automatic t_xor();
        for (int i = 0; i < 4; i++) begin
            test_in = i[1]; presc_out = i[0];
            #0.5;
            chk(main_div_clk, i[1] ^ i[0], "R8 divider clock xor");
        end
        test_in = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lock_build();
        t_drop();
        t_gap_tolerance();
        t_routes();
        t_xor();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule